// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit carries out the conditional-select family of a 64-bit integer pipeline. Each cycle it can accept one 32-bit instruction word together with the two source operands, which the register file has already read, and the current N, Z, C and V flags. It decodes the word and tests the condition against the flags. If the condition holds, it passes the first operand through. If it fails, it takes the second operand and may invert it, increment it, or do both, which negates it. A size bit chooses between full-width operation and 32-bit operation with zero-extension.

The result, the destination index, a write-enable, a "claimed" indication and an undefined-instruction indication are all registered. They appear one cycle after the strobe that carried the instruction, together with a single-cycle valid. A two-state output machine tracks whether the output registers hold a fresh result. In state IDLE the outputs are not valid. In state EMIT they are valid. The transition CAPTURE (IDLE to EMIT) and the transition STREAM (EMIT to EMIT) both occur on an accepted strobe. The transition RETIRE (EMIT to IDLE) occurs when no strobe arrives. A synchronous reset forces IDLE.

Top module: `csel_unit`

## Requirements
- R1: An instruction is claimed only when its bits 28..21 equal 8'b11010100. For any other word, `out_match`, `out_we` and `out_undef` are all 0.
- R2: A claimed word with bit 29 set or bit 11 set is undefined. It gives `out_undef`=1, `out_we`=0 and `out_result`=0.
- R3: When the 4-bit condition in bits 15..12 holds, the result is `op_n`, whatever the values of bits 30 and 10.
- R4: When the condition fails and bits 30 and 10 are both 0, the result is `op_m`.
- R5: When the condition fails, bit 30 is 1 and bit 10 is 0, the result is the bitwise complement of `op_m`.
- R6: When the condition fails, bit 30 is 0 and bit 10 is 1, the result is `op_m` plus one, wrapping at the operand width.
- R7: When the condition fails and both bits 30 and 10 are 1, the result is the two's-complement negation of `op_m`.
- R8: Condition codes 14 and 15 always hold.
- R9: The flag input is ordered {N,Z,C,V} (bit 3 is N). Codes 0..13 test, in order: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !(C&!Z), N==V, N!=V, !Z&(N==V), and !(!Z&(N==V)).
- R10: With bit 31 clear, the unit uses only the low 32 bits of each operand. An increment wraps modulo 2^32. Bits 63..32 of the result are 0.
- R11: The outputs of an instruction appear in the cycle after the rising edge that sampled `in_valid`=1. `out_valid` is 1 exactly in such cycles. Without a strobe the data outputs hold their values.
- R12: While `rst_n` is 0 at a rising edge, `out_valid` and `out_result` become 0 even if a strobe is present.
- R13: For a claimed word, `out_rd` carries bits 4..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe marking an instruction to execute |
| instr | input | 32 | Instruction word |
| op_n | input | 64 | Operand chosen when the condition holds |
| op_m | input | 64 | Operand used on the failing path |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| out_valid | output | 1 | One-cycle marker of a fresh result |
| out_match | output | 1 | The word belongs to this group |
| out_undef | output | 1 | Unallocated encoding inside the group |
| out_we | output | 1 | Destination register write enable |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Value to write |

## Verification
Two functions can fall in the same cycle. The first is the undefined-encoding check. The second is the always-true condition, which by itself would select `op_n` and write it. The bench provokes this overlap with words that carry condition code 14 or 15 while bit 29 or bit 11 is set. It judges the outcome by requiring `out_undef`=1, `out_we`=0 and a zero result. A second overlap is the 32-bit increment wrap combined with zero-extension. The bench drives a failing condition with a low word of all ones and garbage in the upper half, and expects an all-zero result.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int unsigned IW        = 32;
    localparam logic [7:0]  GROUP_SIG = 8'b1101_0100;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_t;

    typedef enum logic [3:0] {
        CC_ZSET  = 4'd0,
        CC_ZCLR  = 4'd1,
        CC_CSET  = 4'd2,
        CC_CCLR  = 4'd3,
        CC_NSET  = 4'd4,
        CC_NCLR  = 4'd5,
        CC_VSET  = 4'd6,
        CC_VCLR  = 4'd7,
        CC_UHI   = 4'd8,
        CC_ULS   = 4'd9,
        CC_SGE   = 4'd10,
        CC_SLT   = 4'd11,
        CC_SGT   = 4'd12,
        CC_SLE   = 4'd13,
        CC_ALW0  = 4'd14,
        CC_ALW1  = 4'd15
    } cc_t;

    typedef struct packed {
        logic       claimed;
        logic       bad_enc;
        logic       wide;
        logic       inv;
        logic       inc;
        cc_t        cc;
        logic [4:0] rd;
    } dec_t;

endpackage

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    logic unused_src_idx;
    assign unused_src_idx = ^{instr[20:16], instr[9:5]};

    always_comb begin
        dec.claimed = (instr[28:21] == GROUP_SIG);
        dec.bad_enc = instr[29] | instr[11];
        dec.wide    = instr[31];
        dec.inv     = instr[30];
        dec.inc     = instr[10];
        dec.cc      = cc_t'(instr[15:12]);
        dec.rd      = instr[4:0];
    end
endmodule

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
    import csel_pkg::*;
(
    input  cc_t        cc,
    input  logic [3:0] flags,
    output logic       pass
);
    logic fn, fz, fc, fv;
    assign {fn, fz, fc, fv} = flags;

    always_comb begin
        unique case (cc)
            CC_ZSET: pass = fz;
            CC_ZCLR: pass = !fz;
            CC_CSET: pass = fc;
            CC_CCLR: pass = !fc;
            CC_NSET: pass = fn;
            CC_NCLR: pass = !fn;
            CC_VSET: pass = fv;
            CC_VCLR: pass = !fv;
            CC_UHI:  pass = fc & !fz;
            CC_ULS:  pass = !(fc & !fz);
            CC_SGE:  pass = (fn == fv);
            CC_SLT:  pass = (fn != fv);
            CC_SGT:  pass = !fz & (fn == fv);
            CC_SLE:  pass = !(!fz & (fn == fv));
            CC_ALW0, CC_ALW1: pass = 1'b1;
            default: pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath #(
    parameter int unsigned XLEN = 64
) (
    input  logic            wide,
    input  logic            inv,
    input  logic            inc,
    input  logic            pass,
    input  logic [XLEN-1:0] op_n,
    input  logic [XLEN-1:0] op_m,
    output logic [XLEN-1:0] result
);
    localparam int unsigned HALF = XLEN / 2;

    logic [XLEN-1:0] alt;
    logic [XLEN-1:0] picked;

    always_comb begin
        alt = op_m;
        if (inv) alt = ~alt;
        if (inc) alt = alt + {{(XLEN-1){1'b0}}, 1'b1};
        picked = pass ? op_n : alt;
    end

    // Narrow mode keeps the low half; the carry out of it is simply dropped.
    assign result = wide ? picked : {{(XLEN-HALF){1'b0}}, picked[HALF-1:0]};
endmodule

// File: rtl/csel_unit.sv
module csel_unit
    import csel_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] op_n,
    input  logic [XLEN-1:0] op_m,
    input  logic [3:0]      flags,
    output logic            out_valid,
    output logic            out_match,
    output logic            out_undef,
    output logic            out_we,
    output logic [4:0]      out_rd,
    output logic [XLEN-1:0] out_result
);
    dec_t            dec;
    logic            pass;
    logic [XLEN-1:0] dp_result;
    out_state_t      state_q, state_d;

    csel_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    csel_cond_eval u_cond (
        .cc    (dec.cc),
        .flags (flags),
        .pass  (pass)
    );

    csel_datapath #(.XLEN(XLEN)) u_dp (
        .wide   (dec.wide),
        .inv    (dec.inv),
        .inc    (dec.inc),
        .pass   (pass),
        .op_n   (op_n),
        .op_m   (op_m),
        .result (dp_result)
    );

    // Transitions: CAPTURE (IDLE->EMIT), STREAM (EMIT->EMIT), RETIRE (EMIT->IDLE)
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_match  <= 1'b0;
            out_undef  <= 1'b0;
            out_we     <= 1'b0;
            out_rd     <= '0;
            out_result <= '0;
        end else if (in_valid) begin
            out_match  <= dec.claimed;
            out_undef  <= dec.claimed & dec.bad_enc;
            out_we     <= dec.claimed & !dec.bad_enc;
            out_rd     <= dec.rd;
            out_result <= (dec.claimed & !dec.bad_enc) ? dp_result : '0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            sf_bit,
    input logic [2:0]      cc_hi,
    input logic [XLEN-1:0] op_n,
    input logic            out_valid,
    input logic            out_match,
    input logic            out_undef,
    input logic            out_we,
    input logic [XLEN-1:0] out_result
);
    localparam int unsigned HALF = XLEN / 2;

    AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));  // R11

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(out_result));  // R11

    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_undef) |-> (!out_we && out_result == '0));  // R2

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_match) |-> (!out_we && !out_undef));  // R1

    AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid && !sf_bit)) |-> (out_result[XLEN-1:HALF] == '0));  // R10

    AST_ALWAYS_TAKES_N: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_we && $past(in_valid && sf_bit && cc_hi == 3'b111))
            |-> (out_result == $past(op_n)));  // R8
endmodule

bind csel_unit csel_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .sf_bit     (instr[31]),
    .cc_hi      (instr[15:13]),
    .op_n       (op_n),
    .out_valid  (out_valid),
    .out_match  (out_match),
    .out_undef  (out_undef),
    .out_we     (out_we),
    .out_result (out_result)
);

// File: tb/csel_unit_bench.sv
`timescale 1ns/1ps
module csel_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] op_n = '0, op_m = '0;
    logic [3:0]  flags = '0;
    logic        out_valid, out_match, out_undef, out_we;
    logic [4:0]  out_rd;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    csel_unit u_csel_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .op_n(op_n), .op_m(op_m), .flags(flags),
        .out_valid(out_valid), .out_match(out_match), .out_undef(out_undef),
        .out_we(out_we), .out_rd(out_rd), .out_result(out_result)
    );

    function automatic logic [31:0] mk(input logic sf, input logic op, input logic s,
                                       input logic [3:0] cc, input logic [1:0] o2,
                                       input logic [4:0] rd);
        return {sf, op, s, 8'b1101_0100, 5'd3, cc, o2, 5'd7, rd};
    endfunction

    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0: return z;        4'd1: return !z;
            4'd2: return cy;       4'd3: return !cy;
            4'd4: return n;        4'd5: return !n;
            4'd6: return v;        4'd7: return !v;
            4'd8: return cy && !z; 4'd9: return !(cy && !z);
            4'd10: return n == v;  4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return !(!z && (n == v));
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                         input logic [3:0] f);
        @(negedge clk);
        instr = w; op_n = a; op_m = b; flags = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R12 reset result", out_result, 64'd0);
    endtask

    task automatic t_foreign;
        issue(32'hFFFF_FFFF ^ 32'h1020_0000, 64'h5, 64'h6, 4'h0);
        chk("R1 foreign match", {63'd0, out_match}, 64'd0);
        chk("R1 foreign we", {63'd0, out_we}, 64'd0);
        chk("R1 foreign undef", {63'd0, out_undef}, 64'd0);
    endtask

    task automatic t_undef;
        issue(mk(1, 0, 1, 4'hE, 2'b00, 5'd9), 64'h77, 64'h88, 4'h0);
        chk("R2 S-bit undef", {63'd0, out_undef}, 64'd1);
        chk("R2 S-bit we", {63'd0, out_we}, 64'd0);
        chk("R2 S-bit result", out_result, 64'd0);
        issue(mk(1, 0, 0, 4'hF, 2'b10, 5'd9), 64'h77, 64'h88, 4'h0);
        chk("R2 op2 undef", {63'd0, out_undef}, 64'd1);
        chk("R2 op2 we", {63'd0, out_we}, 64'd0);
        chk("R2 op2 match", {63'd0, out_match}, 64'd1);
    endtask

    task automatic t_variants;
        logic [63:0] a = 64'h1122_3344_5566_7788;
        logic [63:0] b = 64'h0000_0000_0000_0005;
        // EQ with Z=1 holds; with flags 0 it fails
        issue(mk(1, 1, 0, 4'h0, 2'b01, 5'd4), a, b, 4'b0100);
        chk("R3 taken ignores op bits", out_result, a);
        chk("R13 rd", {59'd0, out_rd}, 64'd4);
        chk("R13 we", {63'd0, out_we}, 64'd1);
        issue(mk(1, 0, 0, 4'h0, 2'b00, 5'd5), a, b, 4'b0000);
        chk("R4 plain else", out_result, 64'h5);
        issue(mk(1, 1, 0, 4'h0, 2'b00, 5'd5), a, b, 4'b0000);
        chk("R5 invert", out_result, 64'hFFFF_FFFF_FFFF_FFFA);
        issue(mk(1, 0, 0, 4'h0, 2'b01, 5'd5), a, b, 4'b0000);
        chk("R6 increment", out_result, 64'h6);
        issue(mk(1, 0, 0, 4'h0, 2'b01, 5'd5), a, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0000);
        chk("R6 increment wrap", out_result, 64'h0);
        issue(mk(1, 1, 0, 4'h0, 2'b01, 5'd5), a, b, 4'b0000);
        chk("R7 negate", out_result, 64'hFFFF_FFFF_FFFF_FFFB);
    endtask

    task automatic t_always;
        for (int c = 14; c < 16; c++) begin
            issue(mk(1, 1, 0, 4'(c), 2'b01, 5'd1), 64'hDEAD_BEEF_0000_0001, 64'h9, 4'h0);
            chk("R8 always", out_result, 64'hDEAD_BEEF_0000_0001);
        end
    endtask

    task automatic t_conds;
        for (int c = 0; c < 14; c++) begin
            for (int f = 0; f < 16; f++) begin
                issue(mk(1, 0, 0, 4'(c), 2'b00, 5'd2), 64'h1, 64'h2, 4'(f));
                chk($sformatf("R9 cond %0d flags %0d", c, f), out_result,
                    cond_ok(4'(c), 4'(f)) ? 64'h1 : 64'h2);
            end
        end
    endtask

    task automatic t_narrow;
        issue(mk(0, 0, 0, 4'h1, 2'b01, 5'd6), 64'h1, 64'hAAAA_AAAA_FFFF_FFFF, 4'b0100);
        chk("R10 narrow wrap", out_result, 64'h0);
        issue(mk(0, 0, 0, 4'h0, 2'b00, 5'd6), 64'h1234_5678_9ABC_DEF0, 64'h0, 4'b0100);
        chk("R10 narrow taken", out_result, 64'h0000_0000_9ABC_DEF0);
        issue(mk(0, 1, 0, 4'h0, 2'b01, 5'd6), 64'h0, 64'h0000_0000_0000_0001, 4'b0000);
        chk("R10 narrow negate", out_result, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_stream;
        @(negedge clk);
        instr = mk(1, 0, 0, 4'hE, 2'b00, 5'd10); op_n = 64'hA; in_valid = 1'b1;
        @(negedge clk);
        chk("R11 first valid", {63'd0, out_valid}, 64'd1);
        chk("R11 first result", out_result, 64'hA);
        instr = mk(1, 0, 0, 4'hE, 2'b00, 5'd11); op_n = 64'hB;
        @(negedge clk);
        in_valid = 1'b0; op_n = 64'hC;
        chk("R11 second result", out_result, 64'hB);
        chk("R11 second rd", {59'd0, out_rd}, 64'd11);
        @(negedge clk);
        chk("R11 retire valid", {63'd0, out_valid}, 64'd0);
        chk("R11 held result", out_result, 64'hB);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        instr = mk(1, 0, 0, 4'hE, 2'b00, 5'd3); op_n = 64'h55; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 reset beats strobe valid", {63'd0, out_valid}, 64'd0);
        chk("R12 reset beats strobe result", out_result, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_foreign;
        t_undef;
        t_variants;
        t_always;
        t_conds;
        t_narrow;
        t_stream;
        t_reset_mid;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run;
    end
endmodule